// File: doc/BRIEF.md
# Station Address Register with Receive-Domain Copy

This block keeps the 48-bit station address of a network port. Software writes it on a 32-bit bus as two words: a low word holding address bits [31:0] and a high word holding bits [47:32] plus fixed flag bits. Each bus byte lane can be written on its own.

The receive path runs on its own clock. It needs a stable copy of the address, so a copy is sent across on a toggle handshake. Only a write to one particular byte lane of the low word starts that transfer, and the endianness select decides which lane it is. All other writes change only the bus-side value. They are carried across by the next triggering write.

On the receive side the block compares the first six bytes of each incoming frame with the copy. The first byte received is compared with the least significant byte of the address. A match flag is set when the sixth byte has arrived, and it stays set until the next frame starts.

Top module: `station_addr_cdc`

## Requirements
- R1: After reset the low word reads 0xFFFFFFFF, the high word reads 0x8000FFFF, and `rx_station` is 0xFFFFFFFFFFFF without any transfer. `frame_hit_valid` is 0.
- R2: `bus_hi_sel`=0 selects the low word. In a write, `bus_be[i]` updates low-word bits [8i+7:8i] from `bus_wdata` and leaves the other bytes unchanged.
- R3: `bus_hi_sel`=1 selects the high word. `bus_be[1:0]` update its bits [15:0] (address bits [47:32]). Bit 31 always reads 1, and bits [30:16] always read 0, whatever is written to them.
- R4: A low-word write starts a transfer when `bus_be[3]`=1 with `big_endian`=0, or when `bus_be[0]`=1 with `big_endian`=1. The transfer carries the full 48-bit value, including the bytes of that same write, into `rx_station` within 4 receive clock cycles.
- R5: Every other write leaves `rx_station` unchanged and does not launch a transfer. This covers any high-word write and any low-word write without the trigger lane.
- R6: `rx_station` only ever changes as a whole. Each value it shows is either the previous value or the complete captured value.
- R7: The byte presented with `rx_sof`=1 and `rx_valid`=1 is compared with `rx_station[7:0]`. The k-th byte of the frame (k = 1 to 6) is compared with bits [8k-1:8k-8]. One receive cycle after the sixth byte, `frame_hit_valid` is 1, and `frame_hit` is 1 only if all six bytes were equal.
- R8: Cycles with `rx_valid`=0 are skipped. `frame_hit_valid` and `frame_hit` keep their values until the next start-of-frame byte, which clears `frame_hit_valid`.
- R9: Bytes after the sixth one of a frame do not change `frame_hit` or `frame_hit_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-side reset, active low |
| bus_hi_sel | input | 1 | Word select: 0 low word, 1 high word |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte-lane enables of the write |
| bus_wdata | input | 32 | Write data |
| big_endian | input | 1 | Selects which low-word lane triggers a transfer |
| bus_rdata | output | 32 | Read data of the selected word |
| rx_clk | input | 1 | Receive clock |
| rx_rst_n | input | 1 | Receive-side reset, active low |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first destination byte of a frame |
| rx_data | input | 8 | Receive byte |
| rx_station | output | 48 | Station address copy in the receive domain |
| frame_hit | output | 1 | Destination address equals the station address |
| frame_hit_valid | output | 1 | `frame_hit` is valid for the current frame |

## Verification
Two bus-side actions can happen in the same clock edge: updating the byte lanes of the low word, and capturing the 48-bit value for transfer. The bench provokes this with a write that enables all four lanes, so that the trigger lane and three ordinary lanes are written together. It then checks that `rx_station` shows every new byte and no old ones. While that transfer is in flight, the bench also samples `rx_station` on every receive cycle and requires it to equal either the old value or the complete new value.

// File: rtl/sta_pkg.sv
package sta_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned HI_W     = 16;
    localparam int unsigned STA_W    = WORD_W + HI_W;
    localparam int unsigned LANES    = WORD_W / BYTE_W;
    localparam int unsigned HI_LANES = HI_W / BYTE_W;
    localparam int unsigned DA_BYTES = STA_W / BYTE_W;
    localparam int unsigned CNT_W    = $clog2(DA_BYTES + 1);

    localparam logic [WORD_W-1:0] LO_RESET = '1;
    localparam logic [HI_W-1:0]   HI_RESET = '1;

    typedef struct packed {
        logic [WORD_W-1:0] lo;
        logic [HI_W-1:0]   hi;
        logic [STA_W-1:0]  cap;
        logic              tog;
    } bus_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             eq;
        logic             done;
        logic             hit;
    } match_state_t;

endpackage

// File: rtl/sta_bus_regs.sv
module sta_bus_regs
    import sta_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_sel,
    input  logic              wr,
    input  logic [LANES-1:0]  be,
    input  logic [WORD_W-1:0] wdata,
    input  logic              big_endian,
    output logic [WORD_W-1:0] rdata,
    output logic [STA_W-1:0]  cap_addr,
    output logic              req_tog
);

    localparam bus_state_t RESET_ST = '{
        lo:  LO_RESET,
        hi:  HI_RESET,
        cap: {HI_RESET, LO_RESET},
        tog: 1'b0
    };

    bus_state_t st_d, st_q;
    logic       trig_lane;
    logic       launch;

    always_comb begin
        st_d      = st_q;
        trig_lane = big_endian ? be[0] : be[LANES-1];
        launch    = 1'b0;
        if (wr) begin
            if (!hi_sel) begin
                for (int b = 0; b < LANES; b++) begin
                    if (be[b]) begin
                        st_d.lo[BYTE_W*b +: BYTE_W] = wdata[BYTE_W*b +: BYTE_W];
                    end
                end
                launch = trig_lane;
            end else begin
                for (int b = 0; b < HI_LANES; b++) begin
                    if (be[b]) begin
                        st_d.hi[BYTE_W*b +: BYTE_W] = wdata[BYTE_W*b +: BYTE_W];
                    end
                end
            end
        end
        if (launch) begin
            st_d.cap = {st_d.hi, st_d.lo};
            st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign rdata    = hi_sel ? {1'b1, {(WORD_W-HI_W-1){1'b0}}, st_q.hi} : st_q.lo;
    assign cap_addr = st_q.cap;
    assign req_tog  = st_q.tog;

    // R4
    trig_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hi_sel && (big_endian ? be[0] : be[LANES-1])) |=> (req_tog != $past(req_tog)));

    // R4
    trig_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hi_sel && !big_endian && be[LANES-1])
        |=> (cap_addr[WORD_W-1 -: BYTE_W] == $past(wdata[WORD_W-1 -: BYTE_W])));

    // R5
    no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && !hi_sel && (big_endian ? be[0] : be[LANES-1]))
        |=> ($stable(req_tog) && $stable(cap_addr)));

endmodule

// File: rtl/sta_rx_sync.sv
module sta_rx_sync
    import sta_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tog,
    input  logic [STA_W-1:0] cap_addr,
    output logic [STA_W-1:0] rx_addr
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   seen;
        logic [STA_W-1:0]       addr;
    } sync_state_t;

    localparam sync_state_t RESET_ST = '{
        sh:   '0,
        seen: 1'b0,
        addr: {HI_RESET, LO_RESET}
    };

    sync_state_t st_d, st_q;
    logic        edge_seen;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[SYNC_STAGES-2:0], req_tog};
        st_d.seen = st_q.sh[SYNC_STAGES-1];
        edge_seen = st_q.sh[SYNC_STAGES-1] != st_q.seen;
        if (edge_seen) begin
            st_d.addr = cap_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign rx_addr = st_q.addr;

    // R6
    whole_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_addr) |-> (rx_addr == $past(cap_addr)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sh[SYNC_STAGES-1] == st_q.seen) |=> $stable(rx_addr));

endmodule

// File: rtl/sta_rx_match.sv
module sta_rx_match
    import sta_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              sof,
    input  logic [BYTE_W-1:0] data,
    input  logic [STA_W-1:0]  addr,
    output logic              hit,
    output logic              hit_valid
);

    localparam match_state_t RESET_ST = '{cnt: '0, eq: 1'b0, done: 1'b0, hit: 1'b0};
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DA_BYTES - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DA_BYTES);

    match_state_t      st_d, st_q;
    logic [CNT_W-1:0]  idx;
    logic [BYTE_W-1:0] exp_byte;
    logic              byte_ok;

    always_comb begin
        idx      = sof ? '0 : st_q.cnt;
        exp_byte = '0;
        for (int k = 0; k < DA_BYTES; k++) begin
            if (idx == CNT_W'(k)) exp_byte = addr[BYTE_W*k +: BYTE_W];
        end
        byte_ok = (data == exp_byte);

        st_d = st_q;
        if (valid) begin
            if (sof) begin
                st_d.cnt  = CNT_W'(1);
                st_d.eq   = byte_ok;
                st_d.done = 1'b0;
                st_d.hit  = 1'b0;
            end else if (st_q.cnt != '0 && st_q.cnt < FULL) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
                st_d.eq  = st_q.eq & byte_ok;
                if (st_q.cnt == LAST) begin
                    st_d.done = 1'b1;
                    st_d.hit  = st_q.eq & byte_ok;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign hit       = st_q.hit;
    assign hit_valid = st_q.done;

    // R8
    sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sof) |=> !hit_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !(valid && sof)) |=> (hit_valid && $stable(hit)));

    // R7
    rise_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_valid) |-> ($past(valid) && !$past(sof)));

endmodule

// File: rtl/station_addr_cdc.sv
module station_addr_cdc #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        bus_clk,
    input  logic        bus_rst_n,
    input  logic        bus_hi_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    input  logic        big_endian,
    output logic [31:0] bus_rdata,
    input  logic        rx_clk,
    input  logic        rx_rst_n,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic [7:0]  rx_data,
    output logic [47:0] rx_station,
    output logic        frame_hit,
    output logic        frame_hit_valid
);

    logic [47:0] cap_addr;
    logic        req_tog;

    sta_bus_regs u_bus (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .hi_sel     (bus_hi_sel),
        .wr         (bus_wr),
        .be         (bus_be),
        .wdata      (bus_wdata),
        .big_endian (big_endian),
        .rdata      (bus_rdata),
        .cap_addr   (cap_addr),
        .req_tog    (req_tog)
    );

    sta_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (rx_clk),
        .rst_n    (rx_rst_n),
        .req_tog  (req_tog),
        .cap_addr (cap_addr),
        .rx_addr  (rx_station)
    );

    sta_rx_match u_match (
        .clk       (rx_clk),
        .rst_n     (rx_rst_n),
        .valid     (rx_valid),
        .sof       (rx_sof),
        .data      (rx_data),
        .addr      (rx_station),
        .hit       (frame_hit),
        .hit_valid (frame_hit_valid)
    );

endmodule

// File: tb/station_addr_cdc_tb_top.sv
`timescale 1ns/1ps
module station_addr_cdc_tb_top;

    logic        bus_clk = 1'b0;
    logic        rx_clk  = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        rx_rst_n  = 1'b0;
    logic        bus_hi_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        big_endian = 1'b0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [47:0] rx_station;
    logic        frame_hit;
    logic        frame_hit_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 bus_clk = ~bus_clk;
    always #4.0 rx_clk  = ~rx_clk;

    station_addr_cdc dut_i (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_hi_sel(bus_hi_sel),
        .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .big_endian(big_endian), .bus_rdata(bus_rdata),
        .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_data(rx_data), .rx_station(rx_station),
        .frame_hit(frame_hit), .frame_hit_valid(frame_hit_valid)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic hi, input logic [3:0] be, input logic [31:0] d);
        @(negedge bus_clk);
        bus_hi_sel = hi; bus_wr = 1'b1; bus_be = be; bus_wdata = d;
        @(negedge bus_clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input logic hi, output logic [31:0] d);
        @(negedge bus_clk);
        bus_hi_sel = hi;
        #1 d = bus_rdata;
    endtask

    task automatic rx_wait(input int n);
        repeat (n) @(negedge rx_clk);
    endtask

    // seq: first byte on the wire in bits [47:40]
    task automatic send_frame(input logic [47:0] seq, input bit gaps);
        for (int k = 0; k < 6; k++) begin
            @(negedge rx_clk);
            rx_valid = 1'b1; rx_sof = (k == 0); rx_data = seq[47-8*k -: 8];
            if (gaps) begin
                @(negedge rx_clk);
                rx_valid = 1'b0; rx_sof = 1'b0; rx_data = 8'h5A;
            end
        end
        @(negedge rx_clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(1'b0, d);
        check(d == 32'hFFFF_FFFF, "R1 low word reset", 64'(d), 64'hFFFF_FFFF);
        bus_read(1'b1, d);
        check(d == 32'h8000_FFFF, "R1 high word reset", 64'(d), 64'h8000_FFFF);
        @(negedge rx_clk);
        check(rx_station == 48'hFFFF_FFFF_FFFF, "R1 rx copy reset", 64'(rx_station), 64'hFFFF_FFFF_FFFF);
        check(!frame_hit_valid, "R1 hit_valid reset", 64'(frame_hit_valid), 64'h0);
        send_frame(48'hFFFF_FFFF_FFFF, 1'b0);
        check(frame_hit_valid && frame_hit, "R1 reset copy matches", 64'({frame_hit_valid, frame_hit}), 64'h3);
    endtask

    task automatic t_lane_writes();
        logic [31:0] d;
        big_endian = 1'b0;
        bus_write(1'b0, 4'b0111, 32'h4433_2211);
        bus_read(1'b0, d);
        check(d == 32'hFF33_2211, "R2 lane merge", 64'(d), 64'hFF33_2211);
        rx_wait(8);
        check(rx_station == 48'hFFFF_FFFF_FFFF, "R5 non-trigger low write", 64'(rx_station), 64'hFFFF_FFFF_FFFF);
    endtask

    task automatic t_high_word();
        logic [31:0] d;
        bus_write(1'b1, 4'b1111, 32'h1234_5566);
        bus_read(1'b1, d);
        check(d == 32'h8000_5566, "R3 high word fixed bits", 64'(d), 64'h8000_5566);
        bus_write(1'b1, 4'b0010, 32'h0000_AB00);
        bus_read(1'b1, d);
        check(d == 32'h8000_AB66, "R3 high lane enable", 64'(d), 64'h8000_AB66);
        bus_write(1'b1, 4'b0010, 32'h0000_5500);
        rx_wait(8);
        check(rx_station == 48'hFFFF_FFFF_FFFF, "R5 high write no transfer", 64'(rx_station), 64'hFFFF_FFFF_FFFF);
    endtask

    task automatic t_trigger(input logic be_mode, input logic [3:0] be, input logic [31:0] d,
                             input logic [47:0] old_v, input logic [47:0] new_v, input string tag);
        int bad = 0;
        big_endian = be_mode;
        bus_write(1'b0, be, d);
        for (int i = 0; i < 4; i++) begin
            @(negedge rx_clk);
            if (rx_station != old_v && rx_station != new_v) bad++;
        end
        check(rx_station == new_v, tag, 64'(rx_station), 64'(new_v));
        for (int i = 0; i < 4; i++) begin
            @(negedge rx_clk);
            if (rx_station != new_v) bad++;
        end
        check(bad == 0, "R6 no partial value", 64'(bad), 64'h0);
    endtask

    task automatic t_endian_lanes();
        // big endian: lane 3 no longer triggers
        big_endian = 1'b1;
        bus_write(1'b0, 4'b1000, 32'hAA00_0000);
        rx_wait(8);
        check(rx_station == 48'h5566_4433_2211, "R5 lane3 ignored in big endian",
              64'(rx_station), 64'h5566_4433_2211);
        t_trigger(1'b1, 4'b0001, 32'h0000_00BB, 48'h5566_4433_2211, 48'h5566_AA33_22BB,
                  "R4 big endian lane0 trigger");
        // little endian: lane 0 no longer triggers
        big_endian = 1'b0;
        bus_write(1'b0, 4'b0001, 32'h0000_00CC);
        rx_wait(8);
        check(rx_station == 48'h5566_AA33_22BB, "R5 lane0 ignored in little endian",
              64'(rx_station), 64'h5566_AA33_22BB);
        t_trigger(1'b0, 4'b1000, 32'hAA00_0000, 48'h5566_AA33_22BB, 48'h5566_AA33_22CC,
                  "R4 carries earlier shadow write");
    endtask

    task automatic t_frames();
        // copy now 0x5566AA3322CC, wire order CC 22 33 AA 66 55
        send_frame(48'hCC22_33AA_6655, 1'b0);
        check(frame_hit_valid && frame_hit, "R7 wire order match", 64'({frame_hit_valid, frame_hit}), 64'h3);
        rx_wait(5);
        check(frame_hit_valid && frame_hit, "R8 result held", 64'({frame_hit_valid, frame_hit}), 64'h3);
        send_frame(48'h5566_AA33_22CC, 1'b0);
        check(frame_hit_valid && !frame_hit, "R7 reversed order misses", 64'({frame_hit_valid, frame_hit}), 64'h2);
        send_frame(48'hCC22_33AA_6654, 1'b1);
        check(frame_hit_valid && !frame_hit, "R7 last byte differs", 64'({frame_hit_valid, frame_hit}), 64'h2);
        send_frame(48'hCC22_33AA_6655, 1'b1);
        check(frame_hit_valid && frame_hit, "R8 idle gaps skipped", 64'({frame_hit_valid, frame_hit}), 64'h3);
        @(negedge rx_clk); rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'h00;
        @(negedge rx_clk); rx_data = 8'hFF;
        @(negedge rx_clk); rx_valid = 1'b0;
        check(frame_hit_valid && frame_hit, "R9 trailing bytes ignored", 64'({frame_hit_valid, frame_hit}), 64'h3);
        @(negedge rx_clk); rx_valid = 1'b1; rx_sof = 1'b1; rx_data = 8'hCC;
        @(negedge rx_clk); rx_valid = 1'b0; rx_sof = 1'b0;
        check(!frame_hit_valid, "R8 sof clears valid", 64'(frame_hit_valid), 64'h0);
    endtask

    initial begin
        #500_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge rx_clk);
        bus_rst_n = 1'b1; rx_rst_n = 1'b1;
        repeat (2) @(negedge rx_clk);
        t_reset();
        t_lane_writes();
        t_high_word();
        // all four lanes in one write: lane update and capture in the same edge
        t_trigger(1'b0, 4'b1111, 32'h4433_2211, 48'hFFFF_FFFF_FFFF, 48'h5566_4433_2211,
                  "R4 little endian full write trigger");
        t_endian_lanes();
        t_frames();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule